// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word addresses of a four-beat burst. A load strobe captures a full word address on a rising clock edge. That address is presented as the first beat. Each later advance changes only the two least significant address bits. The upper bits stay at the captured value until the next load.

The two low bits follow one of two orders, chosen by a static mode input. In interleaved order, the loaded low bits are XORed with a beat count. In linear order, the low bits count up and wrap inside an aligned four-word block. The beat count is modulo four, so advancing past the fourth beat starts the same cycle again. When neither strobe is active, the address is held, which suspends the burst. Memory access, chip-select decoding and data paths are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it is released, addr_o reads all zeros until the first load.
- R2: When load_i is high on a rising edge of clk_i, addr_o equals the sampled addr_i after that edge. This is the first beat.
- R3: Bits ADDR_W-1 down to 2 of addr_o keep the loaded value until the next load, whatever the advances and the mode.
- R4: With mode_i high (interleaved order), the low two bits on beats one to four are the loaded low bits XORed with 00, 01, 10 and 11, in that order.
- R5: With mode_i low (linear order), each advance adds one to the low two bits and wraps 11 to 00. For example, a start of 10 gives 10, 11, 00, 01.
- R6: A rising edge with load_i low and adv_ni high leaves addr_o unchanged, which suspends the burst.
- R7: When load_i is high and adv_ni is low on the same edge, the load wins and addr_o equals the sampled addr_i.
- R8: An advance after the fourth beat continues the same cyclic order, so the fifth beat equals the first.
- R9: addr_i has no effect on addr_o on edges where load_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Burst order: 1 selects interleaved, 0 selects linear; held static in use |
| load_i | input | 1 | Starts a burst at addr_i, active high |
| adv_ni | input | 1 | Steps to the next beat, active low |
| addr_i | input | ADDR_W | Start address of a burst |
| addr_o | output | ADDR_W | Current burst word address |

## Verification
Bursts are run from each of the four low-bit start values in both orders. Interleaved and linear sequences agree on only some beats, so running every start shows which order the design actually applies and whether a fixed offset has been put in place of the XOR. Runs of more than four advances test the modulo-four wrap. Stalls with adv_ni high, with addr_i changing underneath, tell holding apart from free running and show that addr_i is not sampled without a load. A load and an advance asserted on the same edge test the priority between them, and upper address bits with distinct patterns show any leak from the low-bit stepping.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_INTLV  = 1'b1
  } order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end

  // R9
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_ni,
  output beat_t beat_o
);
  // load wins over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (load_i)  beat_o <= '0;
    else if (!adv_ni) beat_o <= beat_o + beat_t'(1);
  end

  // R6
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(beat_o));
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_pkg::*;
(
  input  logic  mode_i,
  input  beat_t start_i,
  input  beat_t beat_i,
  output beat_t low_o
);
  beat_t intlv, lin;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign intlv[b] = start_i[b] ^ beat_i[b];
  end

  assign lin   = start_i + beat_i;
  assign low_o = (order_e'(mode_i) == ORDER_INTLV) ? intlv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              load_i,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  beat_t             beat_q;
  beat_t             low;

  burst_base_reg #(.ADDR_W(ADDR_W)) i_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .addr_i(addr_i),
    .base_o(base_q)
  );

  burst_beat_ctr i_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .adv_ni(adv_ni),
    .beat_o(beat_q)
  );

  burst_low_map i_map (
    .mode_i (mode_i),
    .start_i(base_q[BEAT_W-1:0]),
    .beat_i (beat_q),
    .low_o  (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};

  // R2, R7
  load_first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(addr_i)));

  // R3
  upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R6
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> ($stable(addr_o) || !$stable(mode_i)));

  // R5
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && !mode_i) |=>
      (mode_i || addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));

  // R4: interleaved step flips bit 0 on every advance
  intlv_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && mode_i) |=>
      (!mode_i || addr_o[0] != $past(addr_o[0])));

  initial begin
    assert (UPPER_W >= 1) else $error("ADDR_W too small");
  end
endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 19;

  typedef struct {
    logic [AW-1:0] exp;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b1;
  logic          load = 1'b0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  item_t         sb[$];
  int            n_chk = 0;
  int            n_fail = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk_i (clk),
    .rst_ni(rst_n),
    .mode_i(mode),
    .load_i(load),
    .adv_ni(adv_n),
    .addr_i(addr_in),
    .addr_o(addr_out)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    if (mode) lo = m_base[1:0] ^ m_beat;
    else      lo = 2'(m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit ld, input bit adv, input logic [AW-1:0] a, input string req);
    item_t it;
    @(negedge clk);
    load = ld; adv_n = ~adv; addr_in = a;
    if (ld) begin m_base = a; m_beat = '0; end
    else if (adv) m_beat = m_beat + 2'd1;
    it.exp = model_addr();
    it.req = req;
    sb.push_back(it);
    @(posedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(addr_out, it.exp, it.req);
    end
  end

  task automatic burst(input bit md, input logic [AW-1:0] a, input int advs, input string req);
    @(negedge clk);
    mode = md;
    step(1'b1, 1'b0, a, "R2");
    for (int i = 0; i < advs; i++) step(1'b0, 1'b1, ~a, (i >= 3) ? "R8" : req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(addr_out, '0, "R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check(addr_out, '0, "R1");

    // R4: interleaved, start low bits 01 -> 01,00,11,10 then R8 wrap
    burst(1'b1, 19'h2ABCD, 5, "R4");
    // R6 / R9: suspend with changing addr_i
    step(1'b0, 1'b0, 19'h11111, "R6");
    step(1'b0, 1'b0, 19'h7FFFF, "R9");
    step(1'b0, 1'b1, 19'h00000, "R3");

    // R5: linear, start 10 -> 10,11,00,01 then R8 wrap
    burst(1'b0, 19'h1234E, 5, "R5");
    step(1'b0, 1'b0, 19'h55555, "R9");

    // R7: load and advance together
    step(1'b1, 1'b1, 19'h4F0F3, "R7");
    step(1'b0, 1'b1, 19'h00000, "R5");

    // every start in both orders, with a mid-burst stall
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {17'(17'h0A5A5 + s * 17'h1111), 2'(s)};
        burst(m[0], a, 2, m[0] ? "R4" : "R5");
        step(1'b0, 1'b0, ~a, "R6");
        step(1'b0, 1'b1, a, m[0] ? "R4" : "R5");
        step(1'b0, 1'b1, a, "R3");
      end
    end

    repeat (3) @(posedge clk);
    #3 finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: timeout expired, expected run to end");
    finish_run();
  end
endmodule